// File: doc/BRIEF.md
# Instruction Decoder with Immediate Extender

This block takes one 16-bit instruction word per clock and turns it into everything the execute stage of a small load/store core needs: the two source register indices, a destination index, an ALU operation code, a set of control strobes and a 16-bit operand built from the immediate field. The top 5 bits select the operation. The block recognises three layouts: a three-register layout, an immediate layout (with a 5-bit or an 8-bit immediate) and a jump layout with an 11-bit target.

How the immediate is widened depends on the opcode. It can be sign-extended from 8 bits or from 5 bits. A 5-bit branch offset is sign-extended and then doubled. Logic operands are zero-extended. The load-upper operand is placed in the high byte, and the jump target is doubled. Opcodes that are not assigned raise an illegal flag and turn off every write, memory and control-flow strobe.

The decoded result is registered, so it appears one clock after the word is presented. An active-low asynchronous reset clears it. Executing the operation and reading the register file are left to the neighbouring blocks.

Top module: `instrDecoder`

## Requirements
- R1: While `rstN` is low, every output is 0. This holds from the moment reset is asserted, without waiting for a clock edge.
- R2: The outputs show the decode of the `instr` value sampled at the previous rising clock edge. They do not change between edges.
- R3: `rsIdx` is always `instr[10:8]` and `rtIdx` is always `instr[7:5]`. For opcodes 0 to 5 (add, sub, slt, or, and, xor), `regWrite` is 1, `dstIdx` is `instr[4:2]`, `useImm` is 0 and `immExt` is 0. `aluOp` takes these codes: add 0, sub 1, slt 2, or 3, and 4, xor 5, pass-operand 6.
- R4: Opcode 6 (jump-register) sets only `jumpReg`. `regWrite` is 0, `dstIdx` is 0 and `immExt` is 0.
- R5: Opcode 7 (load) sets `memRead`, `regWrite` and `useImm`, with `dstIdx` = `instr[7:5]`. Opcode 8 (store) sets `memWrite` and `useImm` and leaves `regWrite` at 0. For both, `aluOp` is add and `immExt` is `instr[4:0]` sign-extended from bit 4.
- R6: Opcode 9 (branch if equal) and opcode 10 (branch if not equal) set `branch` and use `aluOp` sub. `branchNe` is set only for opcode 10. `immExt` is `instr[4:0]` sign-extended from bit 4 and shifted left by one, so bit 0 is always 0.
- R7: Opcodes 11 (add-imm) and 12 (sub-imm) write to `dstIdx` = `instr[10:8]` with `useImm` set. `immExt` is `instr[7:0]` sign-extended from bit 7.
- R8: Opcodes 14 (or-imm), 15 (and-imm) and 16 (xor-imm) write to `dstIdx` = `instr[10:8]`. `immExt` is `instr[7:0]` with bits 15:8 forced to 0. `aluOp` is 3, 4 and 5 respectively.
- R9: Opcode 17 (load-upper) writes to `dstIdx` = `instr[10:8]` with `aluOp` 6. `immExt` is `{instr[7:0], 8'h00}`.
- R10: Opcode 18 (jump) sets only `jump`. `immExt` is `instr[10:0]` shifted left by one and zero-extended.
- R11: Opcode 13 and opcodes 19 to 31 set `illegal`. All other strobes, `aluOp`, `dstIdx` and `immExt` are 0.
- R12: At most one of `memRead`, `memWrite`, `branch`, `jump`, `jumpReg` and `illegal` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| instr | input | 16 | Instruction word to decode |
| rsIdx | output | 3 | First source register index |
| rtIdx | output | 3 | Second source register index |
| dstIdx | output | 3 | Destination register index (0 when nothing is written) |
| aluOp | output | 3 | ALU operation code |
| regWrite | output | 1 | Result is written to the register file |
| memRead | output | 1 | Load from memory |
| memWrite | output | 1 | Store to memory |
| branch | output | 1 | Conditional branch |
| branchNe | output | 1 | Branch sense: 1 = not equal |
| jump | output | 1 | Absolute jump to `immExt` |
| jumpReg | output | 1 | Jump to the address held in rs |
| useImm | output | 1 | Second ALU operand is `immExt` |
| illegal | output | 1 | Opcode is not assigned |
| immExt | output | 16 | Extended immediate |

## Verification
Every assigned opcode is presented once, with distinct rs, rt and rd fields, so a swapped destination source (rd, rt or rs) shows as a wrong index. The immediates are chosen with the sign bit both set and clear: 5-bit values of -10, -16, 15 and -1, and 8-bit values 0x81 and 0x7F. These separate sign extension from zero extension, shifted offsets from unshifted ones, and extension taken from the wrong bit. Three unassigned opcodes (the gap at 13, the first above the jump, and all ones) confirm that every strobe is turned off. Directed steps check that the output changes only at a clock edge, and that reset clears the outputs at once in the middle of a run.

// File: rtl/instrDecPkg.sv
package instrDecPkg;

  localparam int OP_W    = 5;
  localparam int IDX_W   = 3;
  localparam int WORD_W  = 16;
  localparam int IMM5_W  = 5;
  localparam int IMM8_W  = 8;
  localparam int IMM11_W = 11;
  localparam int FIELD_W = WORD_W - OP_W;

  localparam logic [OP_W-1:0] OP_ADD  = 5'd0;
  localparam logic [OP_W-1:0] OP_SUB  = 5'd1;
  localparam logic [OP_W-1:0] OP_SLT  = 5'd2;
  localparam logic [OP_W-1:0] OP_OR   = 5'd3;
  localparam logic [OP_W-1:0] OP_AND  = 5'd4;
  localparam logic [OP_W-1:0] OP_XOR  = 5'd5;
  localparam logic [OP_W-1:0] OP_JR   = 5'd6;
  localparam logic [OP_W-1:0] OP_LW   = 5'd7;
  localparam logic [OP_W-1:0] OP_SW   = 5'd8;
  localparam logic [OP_W-1:0] OP_BEQ  = 5'd9;
  localparam logic [OP_W-1:0] OP_BNE  = 5'd10;
  localparam logic [OP_W-1:0] OP_ADDI = 5'd11;
  localparam logic [OP_W-1:0] OP_SUBI = 5'd12;
  localparam logic [OP_W-1:0] OP_ORI  = 5'd14;
  localparam logic [OP_W-1:0] OP_ANDI = 5'd15;
  localparam logic [OP_W-1:0] OP_XORI = 5'd16;
  localparam logic [OP_W-1:0] OP_LUI  = 5'd17;
  localparam logic [OP_W-1:0] OP_J    = 5'd18;

  typedef enum logic [2:0] {
    ALU_ADD  = 3'd0,
    ALU_SUB  = 3'd1,
    ALU_SLT  = 3'd2,
    ALU_OR   = 3'd3,
    ALU_AND  = 3'd4,
    ALU_XOR  = 3'd5,
    ALU_PASS = 3'd6
  } aluOpE;

  typedef enum logic [2:0] {
    IMM_NONE  = 3'd0,
    IMM_SEXT5 = 3'd1,
    IMM_BR5   = 3'd2,
    IMM_SEXT8 = 3'd3,
    IMM_ZEXT8 = 3'd4,
    IMM_UPPER = 3'd5,
    IMM_JMP11 = 3'd6
  } immSelE;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_RD   = 2'd1,
    DST_RT   = 2'd2,
    DST_RS   = 2'd3
  } dstSelE;

  typedef struct packed {
    logic   regWrite;
    logic   memRead;
    logic   memWrite;
    logic   branch;
    logic   branchNe;
    logic   jump;
    logic   jumpReg;
    logic   useImm;
    logic   illegal;
    aluOpE  aluOp;
    immSelE immSel;
    dstSelE dstSel;
  } decStrobesT;

endpackage

// File: rtl/decCtrl.sv
module decCtrl
  import instrDecPkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output decStrobesT      strobes
);

  always_comb begin
    strobes = '0;
    case (opcode)
      OP_ADD, OP_SUB, OP_SLT, OP_OR, OP_AND, OP_XOR: begin
        strobes.regWrite = 1'b1;
        strobes.dstSel   = DST_RD;
        case (opcode)
          OP_SUB:  strobes.aluOp = ALU_SUB;
          OP_SLT:  strobes.aluOp = ALU_SLT;
          OP_OR:   strobes.aluOp = ALU_OR;
          OP_AND:  strobes.aluOp = ALU_AND;
          OP_XOR:  strobes.aluOp = ALU_XOR;
          default: strobes.aluOp = ALU_ADD;
        endcase
      end
      OP_JR: strobes.jumpReg = 1'b1;
      OP_LW: begin
        strobes.memRead  = 1'b1;
        strobes.regWrite = 1'b1;
        strobes.useImm   = 1'b1;
        strobes.dstSel   = DST_RT;
        strobes.immSel   = IMM_SEXT5;
      end
      OP_SW: begin
        strobes.memWrite = 1'b1;
        strobes.useImm   = 1'b1;
        strobes.immSel   = IMM_SEXT5;
      end
      OP_BEQ, OP_BNE: begin
        strobes.branch   = 1'b1;
        strobes.branchNe = (opcode == OP_BNE);
        strobes.aluOp    = ALU_SUB;
        strobes.immSel   = IMM_BR5;
      end
      OP_ADDI, OP_SUBI: begin
        strobes.regWrite = 1'b1;
        strobes.useImm   = 1'b1;
        strobes.dstSel   = DST_RS;
        strobes.immSel   = IMM_SEXT8;
        strobes.aluOp    = (opcode == OP_SUBI) ? ALU_SUB : ALU_ADD;
      end
      OP_ORI, OP_ANDI, OP_XORI: begin
        strobes.regWrite = 1'b1;
        strobes.useImm   = 1'b1;
        strobes.dstSel   = DST_RS;
        strobes.immSel   = IMM_ZEXT8;
        case (opcode)
          OP_ORI:  strobes.aluOp = ALU_OR;
          OP_ANDI: strobes.aluOp = ALU_AND;
          default: strobes.aluOp = ALU_XOR;
        endcase
      end
      OP_LUI: begin
        strobes.regWrite = 1'b1;
        strobes.useImm   = 1'b1;
        strobes.dstSel   = DST_RS;
        strobes.immSel   = IMM_UPPER;
        strobes.aluOp    = ALU_PASS;
      end
      OP_J: begin
        strobes.jump   = 1'b1;
        strobes.immSel = IMM_JMP11;
      end
      default: strobes.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/decData.sv
module decData
  import instrDecPkg::*;
(
  input  logic [FIELD_W-1:0] fields,
  input  immSelE             immSel,
  input  dstSelE             dstSel,
  output logic [IDX_W-1:0]   rsIdx,
  output logic [IDX_W-1:0]   rtIdx,
  output logic [IDX_W-1:0]   dstIdx,
  output logic [WORD_W-1:0]  immExt
);

  localparam int RS_LSB = FIELD_W - IDX_W;
  localparam int RT_LSB = RS_LSB - IDX_W;
  localparam int RD_LSB = RT_LSB - IDX_W;

  logic [IDX_W-1:0] rdField;

  assign rsIdx   = fields[RS_LSB +: IDX_W];
  assign rtIdx   = fields[RT_LSB +: IDX_W];
  assign rdField = fields[RD_LSB +: IDX_W];

  always_comb begin
    case (dstSel)
      DST_RD:  dstIdx = rdField;
      DST_RT:  dstIdx = rtIdx;
      DST_RS:  dstIdx = rsIdx;
      default: dstIdx = '0;
    endcase
  end

  always_comb begin
    case (immSel)
      IMM_SEXT5: immExt = {{(WORD_W-IMM5_W){fields[IMM5_W-1]}}, fields[IMM5_W-1:0]};
      IMM_BR5:   immExt = {{(WORD_W-IMM5_W-1){fields[IMM5_W-1]}}, fields[IMM5_W-1:0], 1'b0};
      IMM_SEXT8: immExt = {{(WORD_W-IMM8_W){fields[IMM8_W-1]}}, fields[IMM8_W-1:0]};
      IMM_ZEXT8: immExt = {{(WORD_W-IMM8_W){1'b0}}, fields[IMM8_W-1:0]};
      IMM_UPPER: immExt = {fields[IMM8_W-1:0], {(WORD_W-IMM8_W){1'b0}}};
      IMM_JMP11: immExt = {{(WORD_W-IMM11_W-1){1'b0}}, fields[IMM11_W-1:0], 1'b0};
      default:   immExt = '0;
    endcase
  end

endmodule

// File: rtl/instrDecoder.sv
module instrDecoder
  import instrDecPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] instr,
  output logic [IDX_W-1:0]  rsIdx,
  output logic [IDX_W-1:0]  rtIdx,
  output logic [IDX_W-1:0]  dstIdx,
  output logic [2:0]        aluOp,
  output logic              regWrite,
  output logic              memRead,
  output logic              memWrite,
  output logic              branch,
  output logic              branchNe,
  output logic              jump,
  output logic              jumpReg,
  output logic              useImm,
  output logic              illegal,
  output logic [WORD_W-1:0] immExt
);

  decStrobesT        strobes;
  logic [IDX_W-1:0]  rsNext, rtNext, dstNext;
  logic [WORD_W-1:0] immNext;

  decCtrl u_ctrl (
    .opcode  (instr[WORD_W-1 -: OP_W]),
    .strobes (strobes)
  );

  decData u_data (
    .fields (instr[FIELD_W-1:0]),
    .immSel (strobes.immSel),
    .dstSel (strobes.dstSel),
    .rsIdx  (rsNext),
    .rtIdx  (rtNext),
    .dstIdx (dstNext),
    .immExt (immNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rsIdx    <= '0;
      rtIdx    <= '0;
      dstIdx   <= '0;
      aluOp    <= '0;
      regWrite <= 1'b0;
      memRead  <= 1'b0;
      memWrite <= 1'b0;
      branch   <= 1'b0;
      branchNe <= 1'b0;
      jump     <= 1'b0;
      jumpReg  <= 1'b0;
      useImm   <= 1'b0;
      illegal  <= 1'b0;
      immExt   <= '0;
    end else begin
      rsIdx    <= rsNext;
      rtIdx    <= rtNext;
      dstIdx   <= dstNext;
      aluOp    <= strobes.aluOp;
      regWrite <= strobes.regWrite;
      memRead  <= strobes.memRead;
      memWrite <= strobes.memWrite;
      branch   <= strobes.branch;
      branchNe <= strobes.branchNe;
      jump     <= strobes.jump;
      jumpReg  <= strobes.jumpReg;
      useImm   <= strobes.useImm;
      illegal  <= strobes.illegal;
      immExt   <= immNext;
    end
  end

  p_fields_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (rsIdx == $past(instr[10:8]) && rtIdx == $past(instr[7:5])));

  p_one_action_r12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memRead, memWrite, branch, jump, jumpReg, illegal}));

  p_illegal_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (!regWrite && !useImm && dstIdx == '0 && immExt == '0));

  p_branch_even_r6: assert property (@(posedge clk) disable iff (!rstN)
    branch |-> (immExt[0] == 1'b0 && !regWrite));

  p_store_nowrite_r5: assert property (@(posedge clk) disable iff (!rstN)
    memWrite |-> (!regWrite && useImm));

  p_upper_low_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (aluOp == ALU_PASS) |-> (immExt[7:0] == 8'h00 && regWrite));

  p_nonwrite_dst_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (jumpReg || jump) |-> (dstIdx == '0 && !regWrite));

endmodule

// File: tb/test_instrDecoder.sv
module test_instrDecoder;

  localparam int NVEC = 23;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] instr = 16'h0000;
  logic [2:0]  rsIdx, rtIdx, dstIdx, aluOp;
  logic        regWrite, memRead, memWrite, branch, branchNe, jump, jumpReg, useImm, illegal;
  logic [15:0] immExt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  instrDecoder i_instrDecoder (
    .clk(clk), .rstN(rstN), .instr(instr),
    .rsIdx(rsIdx), .rtIdx(rtIdx), .dstIdx(dstIdx), .aluOp(aluOp),
    .regWrite(regWrite), .memRead(memRead), .memWrite(memWrite),
    .branch(branch), .branchNe(branchNe), .jump(jump), .jumpReg(jumpReg),
    .useImm(useImm), .illegal(illegal), .immExt(immExt)
  );

  // expected = {dst, aluOp, flags, imm}; flags order:
  // regWrite memRead memWrite branch branchNe jump jumpReg useImm illegal
  localparam logic [15:0] VEC_IN [NVEC] = '{
    16'h014C, 16'h0F17, 16'h1264, 16'h1CB8, 16'h26FD, 16'h2B8A, 16'h35FF,
    16'h3A96, 16'h416F, 16'h4A7F, 16'h514A, 16'h5B81, 16'h667F, 16'h71AA,
    16'h7FF0, 16'h84CC, 16'h8DBE, 16'h9401, 16'h6FFF, 16'h9F00, 16'hFFFF,
    16'h3830, 16'h480F
  };

  localparam logic [30:0] VEC_EXP [NVEC] = '{
    {3'd3, 3'd0, 9'b100000000, 16'h0000},
    {3'd5, 3'd1, 9'b100000000, 16'h0000},
    {3'd1, 3'd2, 9'b100000000, 16'h0000},
    {3'd6, 3'd3, 9'b100000000, 16'h0000},
    {3'd7, 3'd4, 9'b100000000, 16'h0000},
    {3'd2, 3'd5, 9'b100000000, 16'h0000},
    {3'd0, 3'd0, 9'b000000100, 16'h0000},
    {3'd4, 3'd0, 9'b110000010, 16'hFFF6},
    {3'd0, 3'd0, 9'b001000010, 16'h000F},
    {3'd0, 3'd1, 9'b000100000, 16'hFFFE},
    {3'd0, 3'd1, 9'b000110000, 16'h0014},
    {3'd3, 3'd0, 9'b100000010, 16'hFF81},
    {3'd6, 3'd1, 9'b100000010, 16'h007F},
    {3'd1, 3'd3, 9'b100000010, 16'h00AA},
    {3'd7, 3'd4, 9'b100000010, 16'h00F0},
    {3'd4, 3'd5, 9'b100000010, 16'h00CC},
    {3'd5, 3'd6, 9'b100000010, 16'hBE00},
    {3'd0, 3'd0, 9'b000001000, 16'h0802},
    {3'd0, 3'd0, 9'b000000001, 16'h0000},
    {3'd0, 3'd0, 9'b000000001, 16'h0000},
    {3'd0, 3'd0, 9'b000000001, 16'h0000},
    {3'd1, 3'd0, 9'b110000010, 16'hFFF0},
    {3'd0, 3'd1, 9'b000100000, 16'h001E}
  };

  function automatic string reqOf(input logic [4:0] op);
    if (op <= 5'd5)       return "R3";
    else if (op == 5'd6)  return "R4";
    else if (op <= 5'd8)  return "R5";
    else if (op <= 5'd10) return "R6";
    else if (op <= 5'd12) return "R7";
    else if (op == 5'd13) return "R11";
    else if (op <= 5'd16) return "R8";
    else if (op == 5'd17) return "R9";
    else if (op == 5'd18) return "R10";
    else                  return "R11";
  endfunction

  function automatic logic [30:0] observed();
    return {dstIdx, aluOp, regWrite, memRead, memWrite, branch, branchNe,
            jump, jumpReg, useImm, illegal, immExt};
  endfunction

  task automatic check(input string req, input logic [30:0] act, input logic [30:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkOneAction(input string req);
    checks++;
    if ($countones({memRead, memWrite, branch, jump, jumpReg, illegal}) > 1) begin
      fails++;
      $display("FAIL %s: actual %b expected at most one set", req,
               {memRead, memWrite, branch, jump, jumpReg, illegal});
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    #12;
    check("R1", {rsIdx, rtIdx, observed()}, '0);
    @(negedge clk);
    rstN = 1'b1;

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      instr = VEC_IN[i];
      @(posedge clk);
      @(negedge clk);
      check(reqOf(VEC_IN[i][15:11]), observed(), VEC_EXP[i]);
      check("R3", {25'd0, rsIdx, rtIdx}, {25'd0, VEC_IN[i][10:8], VEC_IN[i][7:5]});
      checkOneAction("R12");
    end

    // R2: output holds until the next edge, then follows
    @(negedge clk);
    instr = 16'h014C;
    @(posedge clk);
    #2;
    instr = 16'h9401;
    #2;
    check("R2", observed(), {3'd3, 3'd0, 9'b100000000, 16'h0000});
    @(posedge clk);
    @(negedge clk);
    check("R2", observed(), {3'd0, 3'd0, 9'b000001000, 16'h0802});

    // R1: asynchronous reset mid-run
    @(negedge clk);
    instr = 16'h8DBE;
    @(posedge clk);
    #2;
    rstN = 1'b0;
    #1;
    check("R1", {rsIdx, rtIdx, observed()}, '0);
    @(posedge clk);
    @(negedge clk);
    check("R1", {rsIdx, rtIdx, observed()}, '0);
    rstN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R9", observed(), {3'd5, 3'd6, 9'b100000010, 16'hBE00});

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule